// File: doc/BRIEF.md
# Graphics Command Packet Framer

This block sits on the command input of a graphics engine and cuts a continuous stream of 32-bit command words into whole packets. The top byte of the first word of a packet is the opcode. The opcode sets the packet length, either from a fixed per-opcode count of argument words or, for line-strip opcodes, from a closing marker word. The block collects the words of one packet in a local buffer. It presents the packet downstream only after the last word has arrived. It then streams the packet out word by word, tagged with its opcode, its word count and a packet kind.

Three opcode families get extra treatment. Opcodes that open an image transfer to or from video memory are framed as three-word packets and marked as a read-start or write-start event. A downstream transfer engine takes over the payload that follows. Opcodes in the environment group are single-word packets, and each also writes the whole word into one entry of an eight-entry environment register file, which is exposed as a flat vector. Every other opcode that has no argument count is passed on as a one-word packet.

Both sides use a valid/ready handshake. While a packet is being streamed out, word intake is stopped, so downstream back-pressure never drops a word.

Top module: `cmdfr_framer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and environment entry i (bits 32*i+31 down to 32*i of env_regs) holds (0xE0 + i) shifted left by 24.
- R2: Fixed-length opcodes form packets of this many words: 0x02→3, 0x20–0x23→4, 0x24–0x27→7, 0x28–0x2B→5, 0x2C–0x2F→9, 0x30–0x33→6, 0x34–0x37→9, 0x38–0x3B→8, 0x3C–0x3F→12, 0x40–0x47→3, 0x50–0x57→4, 0x60–0x63→3, 0x64–0x67→4, 0x68–0x6B→2, 0x70–0x73→2, 0x74–0x77→3, 0x78–0x7B→2, 0x7C–0x7F→3, 0x80→4. Their kind is draw (out_kind 0).
- R3: Any opcode that is not covered by R2, R4, R5, R6 or R7 (for example 0x00, 0x6C, 0x81, 0xE8) forms a one-word draw packet, with out_first and out_last both 1.
- R4: For opcodes 0x48–0x4F, the packet ends at the first word at index 3 or later (the first word is index 0) whose value ANDed with 0xF000F000 equals 0x50005000. That closing word is the last word of the packet. Matching words at index 1 or 2 do not end it.
- R5: For opcodes 0x58–0x5F, only words at even indexes of 4 or more are tested against the same closing pattern. A matching word at an odd index is ordinary data. The closing word is included in the packet.
- R6: Opcodes 0xA0–0xDF form three-word packets. out_kind is 2 (transfer read) when the opcode ANDed with 0xE0 equals 0xC0, and 3 (transfer write) otherwise.
- R7: An opcode whose top five bits are 11100 (0xE0–0xE7) writes its whole word into environment entry (opcode AND 7). The write takes effect on the clock edge that accepts the word. The word is also emitted as a one-word packet of kind 1. No other opcode changes any entry.
- R8: out_valid stays 0 while a packet is only partly received, however long the gap before its remaining words.
- R9: While out_valid is 1 and out_ready is 0, the output word and its tags hold steady. in_ready is 0 whenever a packet is being emitted, and every accepted word is emitted exactly once, in order.
- R10: Each emitted word carries out_first on index 0, out_last on the final word, out_opcode equal to the packet's opcode, and out_len equal to the packet's word count.
- R11: A line-strip packet (R4, R5) that reaches MAX_WORDS words without a closing word is closed at MAX_WORDS words. The next input word starts a new packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Framer accepts a word this cycle |
| in_word | input | 32 | Input command word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 32 | Current packet word |
| out_first | output | 1 | Current word is the packet's first |
| out_last | output | 1 | Current word is the packet's last |
| out_opcode | output | 8 | Opcode of the current packet |
| out_len | output | $clog2(MAX_WORDS+1) | Word count of the current packet |
| out_kind | output | 2 | 0 draw, 1 environment, 2 transfer read, 3 transfer write |
| env_regs | output | 256 | Eight environment entries, entry i at bits 32*i+31:32*i |

## Verification
Fixed-length packets are sent with one opcode from every length group, so that an off-by-one or a wrong group boundary shows up as a bad out_last position or out_len. The line-strip cases place closing-pattern words at indexes that must be ignored: index 1 and 2 for the flat form, and odd indexes for the shaded form. These cases separate an index-aware terminator from a plain pattern match. The transfer opcodes at the edges of the 0xA0–0xDF range and inside it check the read/write split. A stalled partial packet, a downstream ready that toggles, and a line strip with no closing word that overruns the buffer cover holding, back-pressure and forced closing.

// File: rtl/cmdfr_pkg.sv
package cmdfr_pkg;

   localparam int unsigned WORD_W        = 32;
   localparam int unsigned OP_W          = 8;
   localparam int unsigned FIX_LEN_W     = 4;
   localparam int unsigned LONGEST_FIXED = 12;
   localparam int unsigned ENV_COUNT     = 8;

   localparam logic [WORD_W-1:0] STRIP_END_MASK  = 32'hF000_F000;
   localparam logic [WORD_W-1:0] STRIP_END_VALUE = 32'h5000_5000;

   typedef enum logic [1:0] {
      KIND_DRAW    = 2'd0,
      KIND_ENV     = 2'd1,
      KIND_VRAM_RD = 2'd2,
      KIND_VRAM_WR = 2'd3
   } pkt_kind_e;

   typedef enum logic [1:0] {
      LEN_FIXED       = 2'd0,
      LEN_STRIP_FLAT  = 2'd1,
      LEN_STRIP_SHADE = 2'd2
   } len_mode_e;

   typedef enum logic {
      PH_COLLECT = 1'b0,
      PH_EMIT    = 1'b1
   } phase_e;

   function automatic logic is_strip_end(input logic [WORD_W-1:0] w);
      return (w & STRIP_END_MASK) == STRIP_END_VALUE;
   endfunction

endpackage

// File: rtl/cmdfr_opdecode.sv
module cmdfr_opdecode
   import cmdfr_pkg::*;
(
   input  logic [OP_W-1:0]      opcode,
   output len_mode_e            len_mode,
   output logic [FIX_LEN_W-1:0] fixed_len,
   output pkt_kind_e            kind
);

   int unsigned extra;

   always_comb begin
      len_mode = LEN_FIXED;
      kind     = KIND_DRAW;
      extra    = 0;
      case (opcode) inside
         8'h02:          extra = 2;
         [8'h20:8'h23]:  extra = 3;
         [8'h24:8'h27]:  extra = 6;
         [8'h28:8'h2B]:  extra = 4;
         [8'h2C:8'h2F]:  extra = 8;
         [8'h30:8'h33]:  extra = 5;
         [8'h34:8'h37]:  extra = 8;
         [8'h38:8'h3B]:  extra = 7;
         [8'h3C:8'h3F]:  extra = 11;
         [8'h40:8'h47]:  extra = 2;
         [8'h48:8'h4F]:  len_mode = LEN_STRIP_FLAT;
         [8'h50:8'h57]:  extra = 3;
         [8'h58:8'h5F]:  len_mode = LEN_STRIP_SHADE;
         [8'h60:8'h63]:  extra = 2;
         [8'h64:8'h67]:  extra = 3;
         [8'h68:8'h6B]:  extra = 1;
         [8'h70:8'h73]:  extra = 1;
         [8'h74:8'h77]:  extra = 2;
         [8'h78:8'h7B]:  extra = 1;
         [8'h7C:8'h7F]:  extra = 2;
         8'h80:          extra = 3;
         [8'hA0:8'hDF]: begin
            extra = 2;
            kind  = ((opcode & 8'hE0) == 8'hC0) ? KIND_VRAM_RD : KIND_VRAM_WR;
         end
         [8'hE0:8'hE7]:  kind = KIND_ENV;
         default:        extra = 0;
      endcase
      fixed_len = FIX_LEN_W'(extra + 1);
   end

endmodule

// File: rtl/cmdfr_env_file.sv
module cmdfr_env_file #(
   parameter int         NUM_REGS = 8,
   parameter int         DATA_W   = 32,
   parameter logic [7:0] TAG_BASE = 8'hE0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(NUM_REGS)-1:0] sel,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

   localparam int SEL_W = $clog2(NUM_REGS);

   if (DATA_W < 8) begin : g_bad_width
      $error("cmdfr_env_file: DATA_W must hold the 8-bit tag");
   end
   if (NUM_REGS < 2) begin : g_bad_count
      $error("cmdfr_env_file: NUM_REGS must be at least 2");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= {TAG_BASE + 8'(g), {(DATA_W-8){1'b0}}};
         end else if (we && sel == SEL_W'(g)) begin
            q <= wdata;
         end
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
   end

endmodule

// File: rtl/cmdfr_word_buf.sv
module cmdfr_word_buf #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [DATA_W-1:0]        rd_data
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cmdfr_word_buf: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cmdfr_framer.sv
module cmdfr_framer
   import cmdfr_pkg::*;
#(
   parameter int MAX_WORDS = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   output logic                            in_ready,
   input  logic [31:0]                     in_word,
   output logic                            out_valid,
   input  logic                            out_ready,
   output logic [31:0]                     out_word,
   output logic                            out_first,
   output logic                            out_last,
   output logic [7:0]                      out_opcode,
   output logic [$clog2(MAX_WORDS+1)-1:0]  out_len,
   output logic [1:0]                      out_kind,
   output logic [255:0]                    env_regs
);

   localparam int IDX_W = $clog2(MAX_WORDS);
   localparam int CNT_W = $clog2(MAX_WORDS + 1);
   localparam int SEL_W = $clog2(ENV_COUNT);

   if (MAX_WORDS < int'(LONGEST_FIXED)) begin : g_bad_depth
      $error("cmdfr_framer: MAX_WORDS must hold the longest fixed packet");
   end

   phase_e               phase_q;
   logic [CNT_W-1:0]     wr_cnt_q;
   logic [IDX_W-1:0]     rd_q;
   logic [CNT_W-1:0]     len_q;
   len_mode_e            mode_q;
   logic [FIX_LEN_W-1:0] fixlen_q;
   pkt_kind_e            kind_q;
   logic [OP_W-1:0]      op_q;

   len_mode_e            dec_mode;
   logic [FIX_LEN_W-1:0] dec_len;
   pkt_kind_e            dec_kind;

   logic                 take;
   logic                 at_head;
   len_mode_e            cur_mode;
   logic [CNT_W-1:0]     cur_len;
   logic                 word_is_end;
   logic                 buf_full;
   logic                 closes;
   logic                 at_tail;
   logic                 env_we;

   cmdfr_opdecode u_decode (
      .opcode    (in_word[31:24]),
      .len_mode  (dec_mode),
      .fixed_len (dec_len),
      .kind      (dec_kind)
   );

   // Intake side: which word closes the packet under collection
   assign take        = in_valid && (phase_q == PH_COLLECT);
   assign at_head     = (wr_cnt_q == '0);
   assign cur_mode    = at_head ? dec_mode : mode_q;
   assign cur_len     = at_head ? CNT_W'(dec_len) : CNT_W'(fixlen_q);
   assign word_is_end = is_strip_end(in_word);
   assign buf_full    = (wr_cnt_q == CNT_W'(MAX_WORDS - 1));

   always_comb begin
      case (cur_mode)
         LEN_STRIP_FLAT:
            closes = (wr_cnt_q >= CNT_W'(3) && word_is_end) || buf_full;
         LEN_STRIP_SHADE:
            closes = (wr_cnt_q >= CNT_W'(4) && !wr_cnt_q[0] && word_is_end) || buf_full;
         default:
            closes = (wr_cnt_q == cur_len - CNT_W'(1));
      endcase
   end

   assign env_we = take && at_head && (in_word[31:27] == 5'b11100);

   cmdfr_word_buf #(
      .DEPTH  (MAX_WORDS),
      .DATA_W (WORD_W)
   ) u_buf (
      .clk     (clk),
      .wr_en   (take),
      .wr_idx  (wr_cnt_q[IDX_W-1:0]),
      .wr_data (in_word),
      .rd_idx  (rd_q),
      .rd_data (out_word)
   );

   cmdfr_env_file #(
      .NUM_REGS (ENV_COUNT),
      .DATA_W   (WORD_W),
      .TAG_BASE (8'hE0)
   ) u_env (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (env_we),
      .sel       (in_word[24 +: SEL_W]),
      .wdata     (in_word),
      .regs_flat (env_regs)
   );

   // Emit side
   assign at_tail = (CNT_W'(rd_q) == len_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_COLLECT;
         wr_cnt_q <= '0;
         rd_q     <= '0;
         len_q    <= '0;
         mode_q   <= LEN_FIXED;
         fixlen_q <= '0;
         kind_q   <= KIND_DRAW;
         op_q     <= '0;
      end else if (take) begin
         if (at_head) begin
            mode_q   <= dec_mode;
            fixlen_q <= dec_len;
            kind_q   <= dec_kind;
            op_q     <= in_word[31:24];
         end
         if (closes) begin
            len_q    <= wr_cnt_q + CNT_W'(1);
            wr_cnt_q <= '0;
            rd_q     <= '0;
            phase_q  <= PH_EMIT;
         end else begin
            wr_cnt_q <= wr_cnt_q + CNT_W'(1);
         end
      end else if (phase_q == PH_EMIT && out_ready) begin
         if (at_tail) begin
            phase_q <= PH_COLLECT;
         end else begin
            rd_q <= rd_q + IDX_W'(1);
         end
      end
   end

   assign in_ready   = (phase_q == PH_COLLECT);
   assign out_valid  = (phase_q == PH_EMIT);
   assign out_first  = (rd_q == '0);
   assign out_last   = at_tail;
   assign out_opcode = op_q;
   assign out_len    = len_q;
   assign out_kind   = kind_q;

endmodule

// File: rtl/cmdfr_checker.sv
module cmdfr_checker
   import cmdfr_pkg::*;
#(
   parameter int MAX_WORDS = 32
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           in_valid,
   input logic                           in_ready,
   input logic                           out_valid,
   input logic                           out_ready,
   input logic [31:0]                    out_word,
   input logic                           out_first,
   input logic                           out_last,
   input logic [7:0]                     out_opcode,
   input logic [$clog2(MAX_WORDS+1)-1:0] out_len,
   input logic [1:0]                     out_kind,
   input logic [255:0]                   env_regs
);

   localparam int CNT_W = $clog2(MAX_WORDS + 1);

   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_first)
                                     && $stable(out_last) && $stable(out_len))); // R9

   AST_NO_INTAKE_DURING_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R9

   AST_FIRST_CARRIES_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_first) |-> (out_opcode == out_word[31:24])); // R10

   AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_len != '0 && out_len <= CNT_W'(MAX_WORDS))); // R11

   AST_ONE_WORD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_len == CNT_W'(1)) |-> (out_first && out_last)); // R3

   AST_TRANSFER_THREE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_kind == KIND_VRAM_RD || out_kind == KIND_VRAM_WR))
         |-> (out_len == CNT_W'(3))); // R6

   AST_ENV_ONLY_ON_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (env_regs != $past(env_regs)) |-> $past(in_valid && in_ready)); // R7

endmodule

bind cmdfr_framer cmdfr_checker #(.MAX_WORDS(MAX_WORDS)) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_word   (out_word),
   .out_first  (out_first),
   .out_last   (out_last),
   .out_opcode (out_opcode),
   .out_len    (out_len),
   .out_kind   (out_kind),
   .env_regs   (env_regs)
);

// File: tb/test_cmdfr_framer.sv
module test_cmdfr_framer;

   localparam int MAX_WORDS = 32;
   localparam int CNT_W     = $clog2(MAX_WORDS + 1);

   typedef struct {
      logic [31:0] w;
      bit          first;
      bit          last;
      int          len;
      logic [1:0]  kind;
      logic [7:0]  op;
      string       req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [31:0]      in_word = '0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [31:0]      out_word;
   logic             out_first;
   logic             out_last;
   logic [7:0]       out_opcode;
   logic [CNT_W-1:0] out_len;
   logic [1:0]       out_kind;
   logic [255:0]     env_regs;

   int    vectors = 0;
   int    miscompares = 0;
   exp_t  expq[$];
   bit    stall_mode = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   bit    was_stalled = 1'b0;
   logic [31:0] held_word = '0;

   always #2 clk = ~clk;

   cmdfr_framer #(.MAX_WORDS(MAX_WORDS)) i_cmdfr_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .in_word    (in_word),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_word   (out_word),
      .out_first  (out_first),
      .out_last   (out_last),
      .out_opcode (out_opcode),
      .out_len    (out_len),
      .out_kind   (out_kind),
      .env_regs   (env_regs)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver side: expected packet into the scoreboard queue
   task automatic expect_pkt(input logic [31:0] words[$], input logic [1:0] kind, input string req);
      for (int i = 0; i < words.size(); i++) begin
         exp_t e;
         e.w = words[i]; e.first = (i == 0); e.last = (i == words.size() - 1);
         e.len = words.size(); e.kind = kind; e.op = words[0][31:24]; e.req = req;
         expq.push_back(e);
      end
   endtask

   // Called at a negedge; returns at the negedge after acceptance
   task automatic drive_word(input logic [31:0] w);
      in_valid = 1'b1;
      in_word  = w;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drive_all(input logic [31:0] words[$]);
      foreach (words[i]) drive_word(words[i]);
   endtask

   task automatic send_pkt(input logic [31:0] words[$], input logic [1:0] kind, input string req);
      expect_pkt(words, kind, req);
      drive_all(words);
   endtask

   task automatic fixed_pkt(input logic [7:0] op, input int len, input string req);
      logic [31:0] w[$];
      w.push_back({op, 24'h000100 + 24'(len)});
      for (int i = 1; i < len; i++) w.push_back(32'h0012_0034 + 32'(i * 17));
      send_pkt(w, 2'd0, req);
   endtask

   task automatic drain();
      while (expq.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // Monitor: drives out_ready and compares accepted words
   always @(negedge clk) begin
      bit r;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      r = stall_mode ? lfsr[0] : 1'b1;
      if (rst_n) begin
         if (was_stalled) begin
            check(out_valid && out_word == held_word, "R9 hold under stall",
                  {31'd0, out_valid, out_word}, {32'd1, held_word});
         end
         if (out_valid) begin
            check(!in_ready, "R9 intake blocked while emitting", 64'(in_ready), 64'd0);
         end
      end
      out_ready = r;
      was_stalled = out_valid && !r && rst_n;
      held_word = out_word;
      if (rst_n && out_valid && r) begin
         if (expq.size() == 0) begin
            check(1'b0, "R9 unexpected word", 64'(out_word), 64'd0);
         end else begin
            exp_t e;
            bit ok;
            e = expq.pop_front();
            ok = (out_word == e.w) && (out_first == e.first) && (out_last == e.last) &&
                 (int'(out_len) == e.len) && (out_kind == e.kind) && (out_opcode == e.op);
            check(ok, {e.req, " R10 fields"},
                  {out_word, out_opcode, 8'(out_len), 6'd0, out_kind, 6'd0, out_first, out_last},
                  {e.w, e.op, 8'(e.len), 6'd0, e.kind, 6'd0, e.first, e.last});
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] w[$];
      repeat (3) @(negedge clk);

      // R1: reset state
      check(!out_valid, "R1 out_valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'd1);
      for (int i = 0; i < 8; i++) begin
         logic [31:0] ex;
         ex = (32'hE0 + 32'(i)) << 24;
         check(env_regs[i*32 +: 32] == ex, "R1 env entry init", 64'(env_regs[i*32 +: 32]), 64'(ex));
      end

      // R3: one-word packets
      w = {32'h0000_0000}; send_pkt(w, 2'd0, "R3 op00");
      w = {32'h6C12_3456}; send_pkt(w, 2'd0, "R3 op6C");
      w = {32'h8100_0001}; send_pkt(w, 2'd0, "R3 op81");
      w = {32'hE812_3456}; send_pkt(w, 2'd0, "R3 opE8");
      drain();
      check(env_regs[0 +: 32] == 32'hE000_0000, "R3 opE8 leaves env entry 0",
            64'(env_regs[0 +: 32]), 64'hE000_0000);

      // R2: one opcode from every fixed-length group
      fixed_pkt(8'h02, 3, "R2 op02");  fixed_pkt(8'h20, 4, "R2 op20");
      fixed_pkt(8'h27, 7, "R2 op27");  fixed_pkt(8'h2B, 5, "R2 op2B");
      fixed_pkt(8'h2C, 9, "R2 op2C");  fixed_pkt(8'h30, 6, "R2 op30");
      fixed_pkt(8'h37, 9, "R2 op37");  fixed_pkt(8'h38, 8, "R2 op38");
      fixed_pkt(8'h3F, 12, "R2 op3F"); fixed_pkt(8'h40, 3, "R2 op40");
      fixed_pkt(8'h57, 4, "R2 op57");  fixed_pkt(8'h60, 3, "R2 op60");
      fixed_pkt(8'h64, 4, "R2 op64");  fixed_pkt(8'h6B, 2, "R2 op6B");
      fixed_pkt(8'h70, 2, "R2 op70");  fixed_pkt(8'h74, 3, "R2 op74");
      fixed_pkt(8'h78, 2, "R2 op78");  fixed_pkt(8'h7C, 3, "R2 op7C");
      fixed_pkt(8'h80, 4, "R2 op80");
      drain();

      // R4: flat strip, pattern at index 1 and 2 ignored
      w = {32'h4800_0000, 32'h5000_5000, 32'h5555_5555, 32'h0010_0010, 32'h5123_5456};
      send_pkt(w, 2'd0, "R4 flat strip");
      w = {32'h4F00_0000, 32'h0001_0001, 32'h0002_0002, 32'h5FFF_5FFF};
      send_pkt(w, 2'd0, "R4 flat strip shortest");

      // R5: shaded strip, odd-index patterns ignored
      w = {32'h5800_0000, 32'h0001_0001, 32'h0000_00FF, 32'h5000_5000,
           32'h0000_FF00, 32'h5000_5000, 32'h5FFF_5FFF};
      send_pkt(w, 2'd0, "R5 shaded strip");
      w = {32'h5C00_0000, 32'h0001_0001, 32'h0000_00FF, 32'h0003_0003, 32'h5000_5000};
      send_pkt(w, 2'd0, "R5 shaded strip shortest");
      drain();

      // R6: image transfers
      w = {32'hA000_0000, 32'h0010_0020, 32'h0004_0004}; send_pkt(w, 2'd3, "R6 opA0 write");
      w = {32'hC000_0000, 32'h5000_5000, 32'h0001_0001}; send_pkt(w, 2'd2, "R6 opC0 read");
      w = {32'hDF00_0000, 32'h0000_0000, 32'h0002_0002}; send_pkt(w, 2'd2, "R6 opDF read");
      w = {32'hBF00_0000, 32'h0000_0001, 32'h0002_0001}; send_pkt(w, 2'd3, "R6 opBF write");
      drain();

      // R7: environment writes
      w = {32'hE3AB_CDEF}; send_pkt(w, 2'd1, "R7 opE3");
      w = {32'hE000_1234}; send_pkt(w, 2'd1, "R7 opE0");
      w = {32'hE7FF_FFFF}; send_pkt(w, 2'd1, "R7 opE7");
      drain();
      check(env_regs[3*32 +: 32] == 32'hE3AB_CDEF, "R7 env entry 3", 64'(env_regs[3*32 +: 32]), 64'hE3AB_CDEF);
      check(env_regs[0 +: 32] == 32'hE000_1234, "R7 env entry 0", 64'(env_regs[0 +: 32]), 64'hE000_1234);
      check(env_regs[7*32 +: 32] == 32'hE7FF_FFFF, "R7 env entry 7", 64'(env_regs[7*32 +: 32]), 64'hE7FF_FFFF);
      check(env_regs[1*32 +: 32] == 32'hE100_0000, "R7 env entry 1 untouched", 64'(env_regs[32 +: 32]), 64'hE100_0000);

      // R8: partial packet held back
      w = {32'h2800_0000, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004};
      expect_pkt(w, 2'd0, "R8 held packet");
      drive_word(w[0]); drive_word(w[1]);
      for (int i = 0; i < 6; i++) begin
         check(!out_valid, "R8 no output while partial", 64'(out_valid), 64'd0);
         @(negedge clk);
      end
      drive_word(w[2]); drive_word(w[3]); drive_word(w[4]);
      drain();

      // R9: downstream back-pressure
      stall_mode = 1'b1;
      fixed_pkt(8'h3C, 12, "R9 stalled op3C");
      fixed_pkt(8'h24, 7, "R9 stalled op24");
      w = {32'h4A00_0000, 32'h0001_0001, 32'h0002_0002, 32'h0003_0003, 32'h5000_5000};
      send_pkt(w, 2'd0, "R9 stalled strip");
      w = {32'hE5AA_0055}; send_pkt(w, 2'd1, "R9 stalled env");
      drain();
      stall_mode = 1'b0;
      check(env_regs[5*32 +: 32] == 32'hE5AA_0055, "R9 env entry 5 after stall", 64'(env_regs[5*32 +: 32]), 64'hE5AA_0055);

      // R11: strip without closing word is cut at MAX_WORDS
      w = {32'h4800_0000};
      for (int i = 1; i < MAX_WORDS; i++) w.push_back(32'h0000_0001 + 32'(i));
      send_pkt(w, 2'd0, "R11 forced close");
      for (int i = 0; i < 4; i++) begin
         logic [31:0] s[$];
         s = {32'h0000_0100 + 32'(i)};
         send_pkt(s, 2'd0, "R11 words after forced close");
      end
      drain();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule